// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the register side of a general-purpose I/O controller. It holds the control state for a set of 16-pin ports, plus a small dedicated pin group, behind a simple 32-bit register bus. For every pin it drives the pad controls: output value, output enable, input enable, a 3-bit function select, a pull selection, a drive-strength index and a slew-rate bit. It also samples the pad inputs through a two-flop synchronizer so that software can read them back.

Each regular port owns a 64-byte window. Port n starts at byte n×0x40. The per-pin single-bit registers (output data, output enable, input enable, slew) use a write-enable halfword. The upper 16 bits of the written word select which pins the lower 16 bits update, so software never needs a read-modify-write. The dedicated group keeps only drive strength and slew rate. These sit at fixed addresses inside window 22, not in the regular layout.

A bus access is a single cycle with `bus_sel` high. `bus_wr` selects a write. Read data appears on `bus_rdata` after the clock edge that accepts the read and holds until the next read.

Top module: `gpb_bank`

## Requirements
- R1: Regular port n (n < NUM_PORTS) decodes at byte address n×0x40 plus an offset. The offsets are: output data 0x00, output enable 0x04, input enable 0x08, function select pins 0–7 at 0x10 and pins 8–15 at 0x14, input data 0x20, pull 0x24, drive 0x28, slew 0x2C, input mask 0x30, enable mask 0x34. A read returns its data on `bus_rdata` one clock after it is accepted.
- R2: For output data, output enable, input enable and slew, a write changes pin bit k only when bit 16+k of the written word is 1; bit k then takes written bit k. The register reads back in bits 15:0, with bits 31:16 reading zero.
- R3: `pad_out`, `pad_oe`, `pad_ie` and `pad_slew` bit 16n+k equal bit k of port n's output data, output enable, input enable and slew registers. They do not change in a cycle without a bus access.
- R4: Function select holds 3 bits per pin in 4-bit nibbles. Pin j of a word sits at nibble j. Bit 3 of each nibble is ignored on write and reads 0. Pin k of port n drives `pad_fsel[(16n+k)*3 +: 3]`.
- R5: Pull (0x24) is a plain 32-bit read/write register with 2 bits per pin. Code 0 means pull-down, 1 means no bias, 2 means pull-up. Pin k of port n drives `pad_pull[(16n+k)*2 +: 2]`.
- R6: Drive strength (0x28) is a plain 32-bit read/write register with a 2-bit level index (0–3) per pin. It drives `pad_drv` with the same layout as R5.
- R7: Input data (0x20) reads pad inputs through two flops, ANDed with the input-enable bits. Writes to it have no effect.
- R8: The input mask (0x30) and the enable mask (0x34) are plain 16-bit read/write registers. Bits 31:16 read zero.
- R9: The dedicated group drive register is at 0x590, with 2 bits per pin, plain read/write, on `ded_drv`. Its slew register is at 0x594, uses the R2 write-enable scheme and drives `ded_slew`.
- R10: Reads of any unmapped address return zero, and writes to one change no register.
- R11: Reset clears every register, so outputs are disabled, inputs are disabled and pull-down is selected. `bus_rdata` also clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pad_in | input | NUM_PORTS×16 | Raw pad inputs |
| pad_out | output | NUM_PORTS×16 | Pad output values |
| pad_oe | output | NUM_PORTS×16 | Pad output enables |
| pad_ie | output | NUM_PORTS×16 | Pad input enables |
| pad_slew | output | NUM_PORTS×16 | Pad slew-rate select |
| pad_fsel | output | NUM_PORTS×48 | Function select, 3 bits per pin |
| pad_pull | output | NUM_PORTS×32 | Pull select, 2 bits per pin |
| pad_drv | output | NUM_PORTS×32 | Drive-strength index, 2 bits per pin |
| ded_drv | output | 2×DED_PINS | Dedicated group drive index |
| ded_slew | output | DED_PINS | Dedicated group slew select |

## Verification
The write-enable registers are tried with all-enable words, partial-nibble enables and a zero-enable word carrying all-ones data. Together these separate a correct merge from one that ignores the enable halfword or writes all bits unconditionally. Plain registers get asymmetric patterns in different ports, which exposes swapped or aliased windows. The function-select words carry nibbles with bit 3 set, which exposes unmasked storage. Input sampling is driven with a pattern only partly covered by input enable, then written over, to separate the AND gating and the read-only behaviour. Reads just past the last port and next to the dedicated registers confirm the zero return.

// File: rtl/gpb_pkg.sv
// Package: shared offsets and decode helpers for the GPIO register bank.
// Assumes word-aligned accesses; address bits 1:0 are ignored by the decoder.
package gpb_pkg;
    localparam int PINS_PER_PORT = 16;
    localparam int WIN_LSB       = 6;   // 64-byte window per port

    localparam logic [5:0] OFF_DOUT    = 6'h00;
    localparam logic [5:0] OFF_OE      = 6'h04;
    localparam logic [5:0] OFF_IE      = 6'h08;
    localparam logic [5:0] OFF_FSEL_LO = 6'h10;
    localparam logic [5:0] OFF_FSEL_HI = 6'h14;
    localparam logic [5:0] OFF_DIN     = 6'h20;
    localparam logic [5:0] OFF_PULL    = 6'h24;
    localparam logic [5:0] OFF_DRV     = 6'h28;
    localparam logic [5:0] OFF_SLEW    = 6'h2C;
    localparam logic [5:0] OFF_DIMASK  = 6'h30;
    localparam logic [5:0] OFF_ENMASK  = 6'h34;

    // Dedicated group registers inside its own window
    localparam logic [5:0] OFF_DED_DRV  = 6'h10;
    localparam logic [5:0] OFF_DED_SLEW = 6'h14;

    // True when an offset names a register in a regular port window
    function automatic logic is_port_off(input logic [5:0] off);
        case (off)
            OFF_DOUT, OFF_OE, OFF_IE, OFF_FSEL_LO, OFF_FSEL_HI, OFF_DIN,
            OFF_PULL, OFF_DRV, OFF_SLEW, OFF_DIMASK, OFF_ENMASK: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/gpb_we_reg.sv
// Module: per-pin register written through a write-enable halfword.
// Bit k takes wdata[k] only when wdata[16+k] is set. Assumes W <= 16.
module gpb_we_reg #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [31:0]   wdata,
    output logic [W-1:0]  q
);
    logic [W-1:0] en;
    logic [W-1:0] val;

    assign en  = wdata[16 +: W];
    assign val = wdata[W-1:0];

    // Merge enabled bits of the written value into the stored state
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= (q & ~en) | (val & en);
    end

    // R2: bits without an enable keep their value
    assert_keep_unenabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & ~$past(en)) == ($past(q) & ~$past(en))));

    // R2: enabled bits take the written value
    assert_take_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(en)) == ($past(val) & $past(en))));

    // R2: no write means no change
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q));
endmodule

// File: rtl/gpb_sync.sv
// Module: two-flop synchronizer for asynchronous pad inputs.
// Assumes each bit is independent; no multi-bit coherency is provided.
module gpb_sync #(
    parameter int W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  d,
    output logic [W-1:0]  q
);
    logic [W-1:0] meta;

    // Two-stage capture of the pad levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpb_port.sv
// Module: register window of one 16-pin port.
// Holds the pad-control registers, samples the pad inputs and returns
// combinational read data for the offset presented. Assumes wr_en is
// already qualified with this port's window select.
module gpb_port
    import gpb_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [5:0]   off,
    input  logic [31:0]  wdata,
    input  logic [15:0]  pad_in,
    output logic [31:0]  rdata,
    output logic [15:0]  dout,
    output logic [15:0]  oe,
    output logic [15:0]  ie,
    output logic [15:0]  slew,
    output logic [47:0]  fsel,
    output logic [31:0]  pull,
    output logic [31:0]  drv
);
    localparam int NP   = PINS_PER_PORT;
    localparam int HALF = NP / 2;

    logic [15:0] dimask;
    logic [15:0] enmask;
    logic [15:0] din_sync;
    logic [2:0]  fsel_q [NP];

    gpb_we_reg #(.W(NP)) u_dout (.clk(clk), .rst_n(rst_n), .wr_en(wr_en && off == OFF_DOUT), .wdata(wdata), .q(dout));
    gpb_we_reg #(.W(NP)) u_oe   (.clk(clk), .rst_n(rst_n), .wr_en(wr_en && off == OFF_OE),   .wdata(wdata), .q(oe));
    gpb_we_reg #(.W(NP)) u_ie   (.clk(clk), .rst_n(rst_n), .wr_en(wr_en && off == OFF_IE),   .wdata(wdata), .q(ie));
    gpb_we_reg #(.W(NP)) u_slew (.clk(clk), .rst_n(rst_n), .wr_en(wr_en && off == OFF_SLEW), .wdata(wdata), .q(slew));

    gpb_sync #(.W(NP)) u_sync (.clk(clk), .rst_n(rst_n), .d(pad_in), .q(din_sync));

    // Function select: one 3-bit field per pin, nibble-spaced in two words
    for (genvar k = 0; k < NP; k++) begin : g_fsel
        localparam logic [5:0] WOFF = (k < HALF) ? OFF_FSEL_LO : OFF_FSEL_HI;
        localparam int         NIB  = k % HALF;

        // Capture the pin's field when its word is written
        always_ff @(posedge clk) begin
            if (!rst_n)                      fsel_q[k] <= '0;
            else if (wr_en && off == WOFF)   fsel_q[k] <= wdata[NIB*4 +: 3];
        end

        assign fsel[k*3 +: 3] = fsel_q[k];
    end

    // Plain read/write registers: pull, drive and the two masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull   <= '0;
            drv    <= '0;
            dimask <= '0;
            enmask <= '0;
        end else if (wr_en) begin
            if (off == OFF_PULL)   pull   <= wdata;
            if (off == OFF_DRV)    drv    <= wdata;
            if (off == OFF_DIMASK) dimask <= wdata[15:0];
            if (off == OFF_ENMASK) enmask <= wdata[15:0];
        end
    end

    // Read-data selection for the addressed offset
    always_comb begin
        rdata = '0;
        case (off)
            OFF_DOUT:    rdata = {16'h0, dout};
            OFF_OE:      rdata = {16'h0, oe};
            OFF_IE:      rdata = {16'h0, ie};
            OFF_SLEW:    rdata = {16'h0, slew};
            OFF_DIN:     rdata = {16'h0, din_sync & ie};
            OFF_PULL:    rdata = pull;
            OFF_DRV:     rdata = drv;
            OFF_DIMASK:  rdata = {16'h0, dimask};
            OFF_ENMASK:  rdata = {16'h0, enmask};
            OFF_FSEL_LO: for (int j = 0; j < HALF; j++) rdata[j*4 +: 4] = {1'b0, fsel_q[j]};
            OFF_FSEL_HI: for (int j = 0; j < HALF; j++) rdata[j*4 +: 4] = {1'b0, fsel_q[j+HALF]};
            default:     rdata = '0;
        endcase
    end

    // R5: pull holds its value outside writes to its own offset
    assert_pull_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && off == OFF_PULL) |=> $stable(pull));

    // R7: input-data readout never shows a pin whose input is disabled
    assert_din_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (off == OFF_DIN) |-> ((rdata[15:0] & ~ie) == 16'h0));
endmodule

// File: rtl/gpb_bank.sv
// Module: top of the GPIO register bank.
// Decodes the byte address into a port window and offset, fans writes
// out to the ports and the dedicated group, and registers read data.
// Assumes NUM_PORTS <= DED_IDX so the dedicated window never overlaps a port.
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DED_IDX   = 22,
    parameter int DED_PINS  = 2,
    parameter int AW        = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [AW-1:0]             bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_PORTS*16-1:0]   pad_in,
    output logic [NUM_PORTS*16-1:0]   pad_out,
    output logic [NUM_PORTS*16-1:0]   pad_oe,
    output logic [NUM_PORTS*16-1:0]   pad_ie,
    output logic [NUM_PORTS*16-1:0]   pad_slew,
    output logic [NUM_PORTS*48-1:0]   pad_fsel,
    output logic [NUM_PORTS*32-1:0]   pad_pull,
    output logic [NUM_PORTS*32-1:0]   pad_drv,
    output logic [2*DED_PINS-1:0]     ded_drv,
    output logic [DED_PINS-1:0]       ded_slew
);
    localparam int PB = AW - WIN_LSB;

    logic [PB-1:0] win;
    logic [5:0]    off;
    logic          wr_any;
    logic          ded_drv_hit;
    logic          ded_slew_hit;
    logic          port_hit;
    logic          any_hit;
    logic [31:0]   rd_mux;
    logic [31:0]   port_rdata [NUM_PORTS];

    assign win    = bus_addr[AW-1:WIN_LSB];
    assign off    = {bus_addr[5:2], 2'b00};
    assign wr_any = bus_sel && bus_wr;

    assign ded_drv_hit  = (win == PB'(DED_IDX)) && (off == OFF_DED_DRV);
    assign ded_slew_hit = (win == PB'(DED_IDX)) && (off == OFF_DED_SLEW);
    assign port_hit     = (32'(win) < NUM_PORTS) && is_port_off(off);
    assign any_hit      = port_hit || ded_drv_hit || ded_slew_hit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpb_port u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_any && win == PB'(p)),
            .off    (off),
            .wdata  (bus_wdata),
            .pad_in (pad_in[p*16 +: 16]),
            .rdata  (port_rdata[p]),
            .dout   (pad_out[p*16 +: 16]),
            .oe     (pad_oe[p*16 +: 16]),
            .ie     (pad_ie[p*16 +: 16]),
            .slew   (pad_slew[p*16 +: 16]),
            .fsel   (pad_fsel[p*48 +: 48]),
            .pull   (pad_pull[p*32 +: 32]),
            .drv    (pad_drv[p*32 +: 32])
        );
    end

    gpb_we_reg #(.W(DED_PINS)) u_ded_slew (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_any && ded_slew_hit),
        .wdata(bus_wdata), .q(ded_slew)
    );

    // Dedicated group drive strength, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)                     ded_drv <= '0;
        else if (wr_any && ded_drv_hit) ded_drv <= bus_wdata[2*DED_PINS-1:0];
    end

    // Select read data from the addressed window
    always_comb begin
        rd_mux = '0;
        if (ded_drv_hit)       rd_mux = 32'(ded_drv);
        else if (ded_slew_hit) rd_mux = 32'(ded_slew);
        else if (port_hit) begin
            for (int p = 0; p < NUM_PORTS; p++)
                if (win == PB'(p)) rd_mux = port_rdata[p];
        end
    end

    // Register read data on an accepted read
    always_ff @(posedge clk) begin
        if (!rst_n)                   bus_rdata <= '0;
        else if (bus_sel && !bus_wr)  bus_rdata <= rd_mux;
    end

    // R10: a read of an unmapped address returns zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !any_hit) |=> (bus_rdata == 32'h0));

    // R3: pad enables change only with a bus access
    assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(pad_oe));

    // R9: dedicated drive moves only on a write to its address
    assert_ded_drv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_any && ded_drv_hit) |=> $stable(ded_drv));
endmodule

// File: tb/gpb_bank_tb_top.sv
// Bench: table-driven register checks followed by directed tests.
module gpb_bank_tb_top;
    localparam int NP = 4;
    localparam int DP = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_sel = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP*16-1:0] pad_in = '0;
    logic [NP*16-1:0] pad_out, pad_oe, pad_ie, pad_slew;
    logic [NP*48-1:0] pad_fsel;
    logic [NP*32-1:0] pad_pull, pad_drv;
    logic [2*DP-1:0]  ded_drv;
    logic [DP-1:0]    ded_slew;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpb_bank #(.NUM_PORTS(NP), .DED_IDX(22), .DED_PINS(DP), .AW(12)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie),
        .pad_slew(pad_slew), .pad_fsel(pad_fsel), .pad_pull(pad_pull),
        .pad_drv(pad_drv), .ded_drv(ded_drv), .ded_slew(ded_slew)
    );

    // Vector: {wr(1), addr(12), wdata(32), expected read(32)}
    localparam int NV = 34;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 12'h004, 32'hFFFF_A5A5, 32'h0},          // R2 full enable
        {1'b0, 12'h004, 32'h0, 32'h0000_A5A5},          // R1 R2
        {1'b1, 12'h004, 32'h00F0_0F0F, 32'h0},          // R2 partial enable
        {1'b0, 12'h004, 32'h0, 32'h0000_A505},
        {1'b1, 12'h004, 32'h0000_FFFF, 32'h0},          // R2 no enable
        {1'b0, 12'h004, 32'h0, 32'h0000_A505},
        {1'b1, 12'h0C0, 32'h8001_FFFF, 32'h0},          // R1 port 3 output data
        {1'b0, 12'h0C0, 32'h0, 32'h0000_8001},
        {1'b1, 12'h050, 32'hFFFF_FFFF, 32'h0},          // R4 bit 3 dropped
        {1'b0, 12'h050, 32'h0, 32'h7777_7777},
        {1'b1, 12'h054, 32'h1234_5678, 32'h0},          // R4 upper pins
        {1'b0, 12'h054, 32'h0, 32'h1234_5670},
        {1'b1, 12'h0A4, 32'hDEAD_BEEF, 32'h0},          // R5
        {1'b0, 12'h0A4, 32'h0, 32'hDEAD_BEEF},
        {1'b1, 12'h068, 32'h1111_2222, 32'h0},          // R6
        {1'b0, 12'h068, 32'h0, 32'h1111_2222},
        {1'b1, 12'h070, 32'hABCD_1234, 32'h0},          // R8 input mask
        {1'b0, 12'h070, 32'h0, 32'h0000_1234},
        {1'b1, 12'h0F4, 32'hFFFF_5555, 32'h0},          // R8 enable mask
        {1'b0, 12'h0F4, 32'h0, 32'h0000_5555},
        {1'b1, 12'h590, 32'hFFFF_FFFF, 32'h0},          // R9 dedicated drive
        {1'b0, 12'h590, 32'h0, 32'h0000_000F},
        {1'b1, 12'h594, 32'h0003_0002, 32'h0},          // R9 dedicated slew
        {1'b0, 12'h594, 32'h0, 32'h0000_0002},
        {1'b1, 12'h594, 32'h0001_0001, 32'h0},          // R9 slew pin 0 only
        {1'b0, 12'h594, 32'h0, 32'h0000_0003},
        {1'b0, 12'h00C, 32'h0, 32'h0},                  // R10 hole in window
        {1'b1, 12'h100, 32'hFFFF_FFFF, 32'h0},          // R10 beyond last port
        {1'b0, 12'h100, 32'h0, 32'h0},
        {1'b0, 12'h598, 32'h0, 32'h0},                  // R10 next to dedicated
        {1'b0, 12'h02C, 32'h0, 32'h0},                  // R2 untouched slew
        {1'b1, 12'h0AC, 32'h0001_0001, 32'h0},          // R2 port 2 slew
        {1'b0, 12'h0AC, 32'h0, 32'h0000_0001},
        {1'b0, 12'h004, 32'h0, 32'h0000_A505}           // R10 unmapped write left port 0 intact
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state
        check("R11 pad_oe", 64'(pad_oe), 64'h0);
        check("R11 pad_pull", 64'(pad_pull[63:0]), 64'h0);
        bus_read(12'h024, rd);
        check("R11 pull read", 64'(rd), 64'h0);

        // Table walk (R1 R2 R4 R5 R6 R8 R9 R10)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) bus_write(VEC[i][75:64], VEC[i][63:32]);
            else begin
                bus_read(VEC[i][75:64], rd);
                check($sformatf("R1 vector %0d", i), 64'(rd), 64'(VEC[i][31:0]));
            end
        end

        // R3 R4 R5 R6 R9: pad outputs follow the registers
        check("R3 pad_oe port0", 64'(pad_oe[15:0]), 64'hA505);
        check("R3 pad_out port3", 64'(pad_out[63:48]), 64'h8001);
        check("R3 pad_slew port2", 64'(pad_slew[47:32]), 64'h0001);
        check("R4 pad_fsel p1 pin9", 64'(pad_fsel[(16+9)*3 +: 3]), 64'h7);
        check("R4 pad_fsel p1 pin15", 64'(pad_fsel[(16+15)*3 +: 3]), 64'h1);
        check("R5 pad_pull port2", 64'(pad_pull[64 +: 32]), 64'hDEAD_BEEF);
        check("R6 pad_drv port1", 64'(pad_drv[32 +: 32]), 64'h1111_2222);
        check("R9 ded_drv", 64'(ded_drv), 64'hF);
        check("R9 ded_slew", 64'(ded_slew), 64'h3);

        // R7: synchronized, gated input data; writes ignored
        bus_write(12'h008, 32'hFFFF_00FF);
        check("R3 pad_ie port0", 64'(pad_ie[15:0]), 64'h00FF);
        @(negedge clk);
        pad_in[15:0] = 16'h3C3C;
        repeat (4) @(negedge clk);
        bus_read(12'h020, rd);
        check("R7 din gated", 64'(rd), 64'h003C);
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read(12'h020, rd);
        check("R7 din write ignored", 64'(rd), 64'h003C);
        pad_in[15:0] = 16'h0000;
        repeat (4) @(negedge clk);
        bus_read(12'h020, rd);
        check("R7 din follows pad", 64'(rd), 64'h0000);

        // R11: reset mid-run clears state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R11 pad_oe after reset", 64'(pad_oe), 64'h0);
        check("R11 ded_drv after reset", 64'(ded_drv), 64'h0);
        bus_read(12'h004, rd);
        check("R11 oe read after reset", 64'(rd), 64'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule